// File: doc/BRIEF.md
# Capture/Compare Counter Array

The block is a 16-bit shared timebase with two capture/compare channels. The counter advances by one on each cycle in which the count-enable tick is high, as long as the run bit is set. Each channel watches its own external input. It can copy the counter into its channel register on a rising edge, on a falling edge, or on both. It can also compare the counter against that register and flag a match. In high-speed output mode the channel also flips its output pin on each match.

Software reaches all state through a small byte-wide register bus with a combinational read port. Software preloads the counter bytes, sets the channel compare values and modes, and clears the sticky flags by writing 1 to them. A single interrupt line combines every enabled flag. When software writes a channel's low compare byte, the comparator switches off. When it writes the high byte, the comparator switches back on. A 16-bit compare value therefore never takes effect half written.

Top module: `pca_timer`

## Requirements
- R1: After reset, every register reads 0, both toggle outputs are 0 and the interrupt output is 0.
- R2: The counter (address 2 low byte, address 3 high byte, both writable) goes up by one on each clock edge where control bit 0 (run) and the tick input are both 1. It holds its value otherwise.
- R3: When the counter wraps from 0xFFFF to 0x0000, the overflow flag (flag register, address 1, bit 0) is set. It stays set until software writes 1 to that bit.
- R4: With mode bit 4 set, a rising edge on a channel's input copies the counter into that channel's capture register. The channel input goes through a two-flop synchroniser. The copy is taken at the third clock edge after the input changes, and it holds the counter value seen just before that edge.
- R5: With mode bit 3 set, a falling edge captures. With bits 4 and 3 both set, either edge captures. An edge that no set bit selects changes neither the capture register nor the flag.
- R6: A channel flag (flag register bit 1 for channel 0, bit 2 for channel 1) is set by a capture or by a match. It stays set until software writes 1 to it.
- R7: A match is an edge where the counter advances to the channel's 16-bit value while mode bit 5 (compare enable) and bit 2 (match) are set. No match occurs when bit 5 is clear, including when the counter wraps to a compare value of 0x0000.
- R8: When mode bit 1 (toggle) is also set, the channel output inverts on each match. It inverts only once per counter value, so it does not invert again while the counter rests on the matched value.
- R9: Writing a channel's low compare byte clears its mode bit 5. Writing its high compare byte sets that bit.
- R10: The interrupt output is high exactly when an enabled flag is set. The overflow flag is enabled by control bit 1, and each channel flag by that channel's mode bit 0.
- R11: The mode register sits at address 4 for channel 0 and 8 for channel 1. The low compare byte is at base+1 and the high byte at base+2. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cnt_tick | input | 1 | Count enable tick |
| ext_in | input | 2 | Channel capture inputs (asynchronous) |
| tgl_out | output | 2 | Channel toggle outputs |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a match at a precise count value, and above all one that coincides with the 0xFFFF-to-0x0000 wrap. A free-running counter would take tens of thousands of cycles to get there. The stimulus preloads the counter through the bus and arms a compare value a random small distance ahead. It then issues an exact number of ticks, so the edge just before the match and the match edge itself can both be observed. Capture timing is checked with the counter stopped, and also while it runs, to confirm the three-edge synchroniser latency.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 6;

  localparam int A_CTRL  = 0;
  localparam int A_FLAG  = 1;
  localparam int A_CNTLO = 2;
  localparam int A_CNTHI = 3;
  localparam int CH_STRIDE = 4;

  // Channel mode bits, MSB first: bit5 compare enable, bit4 capture on rise,
  // bit3 capture on fall, bit2 match flag enable, bit1 toggle, bit0 irq enable
  typedef struct packed {
    logic cmp_en;
    logic cap_rise;
    logic cap_fall;
    logic mat_en;
    logic tog_en;
    logic irq_en;
  } ch_mode_t;
endpackage

// File: rtl/pca_sync_edge.sv
module pca_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = din;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;

  // R4: an edge is reported for a single cycle only
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/pca_counter.sv
module pca_counter
  import pca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_inc_o,
  output logic              step_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             ovf_q, ovf_d;
  logic             adv, wrap, step;

  always_comb begin
    adv     = run_i & tick_i;
    cnt_inc = cnt_q + CNT_W'(1);
    wrap    = adv & (&cnt_q);
    step    = adv & ~wr_lo_i & ~wr_hi_i;
    cnt_d   = cnt_q;
    if (adv)     cnt_d = cnt_inc;
    if (wr_lo_i) cnt_d[BYTE_W-1:0] = wdata_i;
    if (wr_hi_i) cnt_d[CNT_W-1:BYTE_W] = wdata_i;
    ovf_d   = wrap | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_inc_o = cnt_inc;
  assign step_o    = step;
  assign ovf_o     = ovf_q;

  // R2: counter holds unless running with a tick or written
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_i && tick_i) && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  // R2: a clean step adds exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3: overflow flag is sticky until cleared
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_inc_i,
  input  logic              step_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mode_wr_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              flag_clr_i,
  output ch_mode_t          mode_o,
  output logic [CNT_W-1:0]  val_o,
  output logic              flag_o,
  output logic              tgl_o
);
  ch_mode_t         mode_q, mode_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic             flag_q, flag_d;
  logic             tgl_q, tgl_d;
  logic             cap_evt, match_evt;

  always_comb begin
    cap_evt   = (mode_q.cap_rise & rise_i) | (mode_q.cap_fall & fall_i);
    match_evt = step_i & mode_q.cmp_en & mode_q.mat_en & (cnt_inc_i == val_q);

    mode_d = mode_q;
    if (mode_wr_i) mode_d = ch_mode_t'(wdata_i[MODE_W-1:0]);
    if (lo_wr_i)   mode_d.cmp_en = 1'b0;
    if (hi_wr_i)   mode_d.cmp_en = 1'b1;

    val_d = val_q;
    if (cap_evt) val_d = cnt_i;
    if (lo_wr_i) val_d[BYTE_W-1:0] = wdata_i;
    if (hi_wr_i) val_d[CNT_W-1:BYTE_W] = wdata_i;

    flag_d = cap_evt | match_evt | (flag_q & ~flag_clr_i);
    tgl_d  = tgl_q ^ (match_evt & mode_q.tog_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      val_q  <= '0;
      flag_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      val_q  <= val_d;
      flag_q <= flag_d;
      tgl_q  <= tgl_d;
    end
  end

  assign mode_o = mode_q;
  assign val_o  = val_q;
  assign flag_o = flag_q;
  assign tgl_o  = tgl_q;

  // R4: a capture without a bus write stores the counter seen at that edge
  p_capture_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !lo_wr_i && !hi_wr_i) |=> (val_q == $past(cnt_i)));
  // R6: channel flag sticky until cleared
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q);
  // R8: output only moves when the counter steps
  p_toggle_needs_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(tgl_q));
  // R9: low byte write disarms, high byte write arms
  p_lo_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_i && !hi_wr_i) |=> !mode_q.cmp_en);
  p_hi_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_i |=> mode_q.cmp_en);
endmodule

// File: rtl/pca_timer.sv
module pca_timer
  import pca_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SYNC_LEN = 2,
  localparam int ADDR_W  = $clog2(CH_STRIDE * (NUM_CH + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cnt_tick,
  input  logic [NUM_CH-1:0] ext_in,
  output logic [NUM_CH-1:0] tgl_out,
  output logic              irq
);
  logic             run_q, run_d, ovf_ie_q, ovf_ie_d;
  logic             ctrl_wr, flag_wr;
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic             step, ovf;

  logic [NUM_CH-1:0]            ch_rise, ch_fall, ch_flag, ch_irq;
  logic [NUM_CH-1:0]            ch_mode_wr, ch_lo_wr, ch_hi_wr;
  ch_mode_t [NUM_CH-1:0]        ch_mode;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_val;

  always_comb begin
    ctrl_wr  = reg_wr && (int'(reg_addr) == A_CTRL);
    flag_wr  = reg_wr && (int'(reg_addr) == A_FLAG);
    run_d    = run_q;
    ovf_ie_d = ovf_ie_q;
    if (ctrl_wr) begin
      run_d    = reg_wdata[0];
      ovf_ie_d = reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ovf_ie_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      ovf_ie_q <= ovf_ie_d;
    end
  end

  pca_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .tick_i    (cnt_tick),
    .wr_lo_i   (reg_wr && (int'(reg_addr) == A_CNTLO)),
    .wr_hi_i   (reg_wr && (int'(reg_addr) == A_CNTHI)),
    .wdata_i   (reg_wdata),
    .ovf_clr_i (flag_wr && reg_wdata[0]),
    .cnt_o     (cnt),
    .cnt_inc_o (cnt_inc),
    .step_o    (step),
    .ovf_o     (ovf)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int BASE = CH_STRIDE * (c + 1);

      assign ch_mode_wr[c] = reg_wr && (int'(reg_addr) == BASE);
      assign ch_lo_wr[c]   = reg_wr && (int'(reg_addr) == BASE + 1);
      assign ch_hi_wr[c]   = reg_wr && (int'(reg_addr) == BASE + 2);

      pca_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (ext_in[c]),
        .rise_o (ch_rise[c]),
        .fall_o (ch_fall[c])
      );

      pca_channel u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .cnt_inc_i  (cnt_inc),
        .step_i     (step),
        .rise_i     (ch_rise[c]),
        .fall_i     (ch_fall[c]),
        .mode_wr_i  (ch_mode_wr[c]),
        .lo_wr_i    (ch_lo_wr[c]),
        .hi_wr_i    (ch_hi_wr[c]),
        .wdata_i    (reg_wdata),
        .flag_clr_i (flag_wr && reg_wdata[1 + c]),
        .mode_o     (ch_mode[c]),
        .val_o      (ch_val[c]),
        .flag_o     (ch_flag[c]),
        .tgl_o      (tgl_out[c])
      );

      assign ch_irq[c] = ch_flag[c] & ch_mode[c].irq_en;
    end
  endgenerate

  assign irq = (ovf & ovf_ie_q) | (|ch_irq);

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      A_CTRL:  reg_rdata = {6'b0, ovf_ie_q, run_q};
      A_FLAG: begin
        reg_rdata[0] = ovf;
        for (int c = 0; c < NUM_CH; c++) reg_rdata[1 + c] = ch_flag[c];
      end
      A_CNTLO: reg_rdata = cnt[BYTE_W-1:0];
      A_CNTHI: reg_rdata = cnt[CNT_W-1:BYTE_W];
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (int'(reg_addr) == CH_STRIDE * (c + 1))
            reg_rdata = {{(8 - MODE_W){1'b0}}, ch_mode[c]};
          if (int'(reg_addr) == CH_STRIDE * (c + 1) + 1)
            reg_rdata = ch_val[c][BYTE_W-1:0];
          if (int'(reg_addr) == CH_STRIDE * (c + 1) + 2)
            reg_rdata = ch_val[c][CNT_W-1:BYTE_W];
        end
      end
    endcase
  end

  // R10: an interrupt needs some set flag behind it
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf || (|ch_flag)));
  // R2: the run bit follows control writes only
  p_run_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(run_q));
endmodule

// File: tb/tb_pca_timer.sv
module tb_pca_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cnt_tick;
  logic [1:0] ext_in;
  logic [1:0] tgl_out;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pca_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_tick(cnt_tick),
    .ext_in(ext_in), .tgl_out(tgl_out), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int mode_addr(int c); return 4 * (c + 1); endfunction
  function automatic logic [15:0] add16(logic [15:0] a, int n);
    return a + 16'(n);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    rd(2, lo); rd(3, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic rd_val(int c, output int v);
    int lo, hi;
    rd(mode_addr(c) + 1, lo); rd(mode_addr(c) + 2, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(2, v[7:0]); wr(3, v[15:8]);
  endtask

  task automatic tick_n(int n);
    if (n > 0) begin
      @(negedge clk);
      cnt_tick = 1'b1;
      repeat (n) @(negedge clk);
      cnt_tick = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, v;
    logic [1:0] exp_tgl;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    cnt_tick = 1'b0; ext_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 address map readback
    for (int a = 0; a < 12; a++) begin
      rd(a, d);
      check($sformatf("R1 R11 addr %0d", a), d, 0);
    end
    check("R1 tgl_out", int'(tgl_out), 0);
    check("R1 irq", int'(irq), 0);

    // R2 load, hold while stopped, count while running
    set_cnt(16'h1234);
    rd_cnt(v); check("R2 load", v, 'h1234);
    tick_n(5);
    rd_cnt(v); check("R2 hold when stopped", v, 'h1234);
    wr(0, 1);
    tick_n(7);
    rd_cnt(v); check("R2 count", v, 'h123B);
    repeat (3) @(negedge clk);
    rd_cnt(v); check("R2 hold without tick", v, 'h123B);

    // R3 overflow flag
    set_cnt(16'hFFFE);
    tick_n(1);
    rd(1, d); check("R3 no flag before wrap", d & 1, 0);
    tick_n(1);
    rd_cnt(v); check("R3 wrap value", v, 0);
    rd(1, d); check("R3 flag on wrap", d & 1, 1);
    tick_n(3);
    rd(1, d); check("R3 sticky", d & 1, 1);
    check("R10 irq off while disabled", int'(irq), 0);
    wr(0, 3);
    #1 check("R10 irq from overflow", int'(irq), 1);
    wr(1, 1);
    rd(1, d); check("R3 cleared", d & 1, 0);
    check("R10 irq drops", int'(irq), 0);
    wr(0, 1);

    // R9 arm/disarm through compare byte writes
    wr(4, 'h24);
    wr(5, 'h10);
    rd(4, d); check("R9 low write disarms", d, 'h04);
    wr(6, 'h00);
    rd(4, d); check("R9 high write arms", d, 'h24);

    // R7 disarmed comparator ignores the value
    wr(4, 'h26); wr(6, 'h01); wr(5, 'h05);
    rd(4, d); check("R9 disarmed mode", d, 'h06);
    wr(1, 7);
    set_cnt(16'h0100);
    tick_n(10);
    rd(1, d); check("R7 no match when disarmed", (d >> 1) & 1, 0);
    check("R8 no toggle when disarmed", int'(tgl_out[0]), 0);

    // R6 R7 R8 random matches
    exp_tgl = tgl_out;
    for (int it = 0; it < 16; it++) begin
      int c, k, j;
      logic [15:0] p, cv;
      c  = $urandom % 2;
      k  = 1 + ($urandom % 20);
      j  = 1 + ($urandom % 10);
      p  = 16'($urandom);
      cv = add16(p, k);
      wr(mode_addr(1 - c), 0);
      wr(mode_addr(c), 'h26);
      wr(mode_addr(c) + 1, cv[7:0]);
      wr(mode_addr(c) + 2, cv[15:8]);
      set_cnt(p);
      wr(1, 7);
      tick_n(k - 1);
      rd(1, d); check("R7 no flag before match", (d >> (1 + c)) & 1, 0);
      check("R8 no toggle before match", int'(tgl_out[c]), int'(exp_tgl[c]));
      tick_n(1);
      exp_tgl[c] = ~exp_tgl[c];
      rd(1, d); check("R6 R7 flag on match", (d >> (1 + c)) & 1, 1);
      check("R8 toggle on match", int'(tgl_out[c]), int'(exp_tgl[c]));
      repeat (4) @(negedge clk);
      check("R8 once per value", int'(tgl_out[c]), int'(exp_tgl[c]));
      tick_n(j);
      rd(1, d); check("R6 flag sticky", (d >> (1 + c)) & 1, 1);
      check("R8 no extra toggle", int'(tgl_out[c]), int'(exp_tgl[c]));
    end

    // R7 R3 match exactly at the wrap
    wr(8, 0);
    wr(4, 'h27); wr(5, 0); wr(6, 0);
    set_cnt(16'hFFFF);
    wr(1, 7);
    tick_n(1);
    exp_tgl[0] = ~exp_tgl[0];
    rd(1, d); check("R7 R3 match and wrap flags", d & 3, 3);
    check("R8 toggle at wrap", int'(tgl_out[0]), int'(exp_tgl[0]));
    check("R10 irq from channel", int'(irq), 1);
    wr(1, 2);
    check("R10 irq after channel clear", int'(irq), 0);
    wr(1, 1);

    // R4 R5 captures with the counter stopped
    wr(0, 0); wr(4, 0); wr(8, 0);
    for (int c = 0; c < 2; c++) begin
      logic [15:0] v1, v2;
      v1 = 16'($urandom); v2 = ~v1;
      wr(mode_addr(c), 'h10);
      set_cnt(v1); wr(1, 7);
      @(negedge clk); ext_in[c] = 1'b1;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R4 rising capture", v, int'(v1));
      rd(1, d); check("R6 flag on capture", (d >> (1 + c)) & 1, 1);
      set_cnt(v2); wr(1, 7);
      @(negedge clk); ext_in[c] = 1'b0;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R5 fall ignored in rise mode", v, int'(v1));
      rd(1, d); check("R5 no flag on ignored edge", (d >> (1 + c)) & 1, 0);
      wr(mode_addr(c), 'h08);
      @(negedge clk); ext_in[c] = 1'b1;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R5 rise ignored in fall mode", v, int'(v1));
      @(negedge clk); ext_in[c] = 1'b0;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R5 falling capture", v, int'(v2));
      wr(mode_addr(c), 'h18);
      set_cnt(v1);
      @(negedge clk); ext_in[c] = 1'b1;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R5 both edges rise", v, int'(v1));
      set_cnt(16'h00AA);
      @(negedge clk); ext_in[c] = 1'b0;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R5 both edges fall", v, 'h00AA);
      wr(mode_addr(c), 'h00); wr(1, 7);
      set_cnt(16'h5555);
      @(negedge clk); ext_in[c] = 1'b1;
      repeat (4) @(negedge clk);
      rd_val(c, v); check("R5 no capture bits", v, 'h00AA);
      rd(1, d); check("R5 no flag without capture bits", (d >> (1 + c)) & 1, 0);
      @(negedge clk); ext_in[c] = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R4 latency with the counter running
    wr(4, 'h10);
    set_cnt(16'h0200);
    wr(0, 1);
    @(negedge clk);
    ext_in[0] = 1'b1; cnt_tick = 1'b1;
    repeat (6) @(negedge clk);
    cnt_tick = 1'b0;
    rd_val(0, v); check("R4 capture latency", v, 'h0202);
    ext_in[0] = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule